// File: doc/BRIEF.md
# Multi-channel selectable clock prescaler

This block turns one source clock into three independent rate strobes. Two of them serve 8-bit timer channels (timer 2 and timer 3) and one serves an A/D converter. All three channels share a single free-running binary divider counter. Each channel picks one counter bit as its tap through a 3-bit ratio code. It emits a one-cycle enable pulse in the source clock domain every time that bit falls from 1 to 0, which gives exactly one pulse in every N cycles.

Software programs each channel through two byte-wide configuration registers. Each channel has a run bit and a ratio code. A run bit turns its channel off at once. Other changes to a channel's settings wait for a counter wrap, so that no pulse interval is ever shortened. A master prescaler enable comes from outside the block. When it is low, the divider counter freezes and every output stays low. The two timer channels decode the same low codes, but the timer 2 channel maps its two top codes onto much longer ratios.

Top module: `presc_top`

## Requirements
- R1: On every channel, ratio codes 0 to 5 give one tick every 2, 4, 8, 16, 32 and 64 cycles respectively.
- R2: On the timer 3 and A/D channels, code 6 gives one tick every 128 cycles and code 7 gives one tick every 256 cycles.
- R3: On the timer 2 channel, code 6 gives one tick every 2048 cycles and code 7 gives one tick every 4096 cycles.
- R4: Each tick is high for exactly one cycle and is never high on two consecutive cycles.
- R5: While `presc_on` is low, all three ticks stay low and the divider holds its count. When `presc_on` returns high, the ticks resume at their programmed rates.
- R6: After reset, both configuration registers read 0x00 and all ticks are low.
- R7: The register at address 0 holds the timer 2 code in bits [2:0], the timer 2 run bit in bit 3, the timer 3 code in bits [6:4] and the timer 3 run bit in bit 7. The register at address 1 holds the A/D code in bits [2:0] and the A/D run bit in bit 3, and its bits [7:4] always read 0.
- R8: A change of ratio code on a running channel takes effect at the wrap of the wider of the old and new taps, so every interval between ticks equals either the old period or the new one.
- R9: A write that clears a channel's run bit keeps that channel's tick low from the very next cycle onward, including a tick that was already due.
- R10: The channels run independently: different codes on the three channels produce their own rates at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_on | input | 1 | Master divider enable, held in an external protected register |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 1 | Register select for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| tick_tmr2 | output | 1 | Enable strobe for timer channel 2 |
| tick_tmr3 | output | 1 | Enable strobe for timer channel 3 |
| tick_adc | output | 1 | Enable strobe for the A/D converter |

## Verification
The assertions check properties that hold on every cycle: no tick is ever high on two consecutive cycles, the counter and all ticks stay quiet the cycle after the master enable is low, a run-bit clear suppresses the next tick, and the reserved read bits stay zero. The actual division ratios for every code on every channel can only be shown by the bench's scenarios, which count pulses over exact multiples of the period. The bench scenarios also show that no interval is shortened across a ratio change, and that the three rates run together without interfering.

// File: rtl/presc_pkg.sv
package presc_pkg;

    typedef logic [2:0] ratio_t;

    typedef struct packed {
        logic   on;
        ratio_t code;
    } chan_cfg_t;

    localparam int NUM_CH = 3;
    localparam int CH_TMR2 = 0;
    localparam int CH_TMR3 = 1;
    localparam int CH_ADC  = 2;

endpackage

// File: rtl/presc_divider.sv
module presc_divider #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    output logic [CNT_W-1:0] fall
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // bit k falls on the increment that follows all ones in bits [k:0]
    for (genvar k = 0; k < CNT_W; k++) begin : g_fall
        assign fall[k] = run & (&st_q.cnt[k:0]);
    end

    // R5
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(st_q.cnt));

endmodule

// File: rtl/presc_regs.sv
module presc_regs
    import presc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic                    addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output chan_cfg_t [NUM_CH-1:0]  cfg,
    output logic [NUM_CH-1:0]       kill
);
    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] ch;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        kill = '0;
        if (we) begin
            if (!addr) begin
                st_d.ch[CH_TMR2] = wdata[3:0];
                st_d.ch[CH_TMR3] = wdata[7:4];
                kill[CH_TMR2]    = ~wdata[3];
                kill[CH_TMR3]    = ~wdata[7];
            end else begin
                st_d.ch[CH_ADC]  = wdata[3:0];
                kill[CH_ADC]     = ~wdata[3];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg   = st_q.ch;
    assign rdata = addr ? {4'b0000, st_q.ch[CH_ADC]}
                        : {st_q.ch[CH_TMR3], st_q.ch[CH_TMR2]};

    // R7
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr |-> (rdata[7:4] == 4'b0000));

endmodule

// File: rtl/presc_channel.sv
module presc_channel
    import presc_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter bit WIDE       = 1'b0,
    parameter int WIDE_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  chan_cfg_t        cfg,
    input  logic             kill,
    input  logic [CNT_W-1:0] fall,
    output logic             tick
);
    localparam int TAP_W = $clog2(CNT_W);

    typedef struct packed {
        logic             act_on;
        logic [TAP_W-1:0] act_tap;
        logic             tick;
    } ch_state_t;

    ch_state_t st_d, st_q;

    function automatic logic [TAP_W-1:0] tap_of(ratio_t code);
        if (WIDE && code >= 3'd6) return TAP_W'(code) + TAP_W'(WIDE_SHIFT);
        return TAP_W'(code);
    endfunction

    logic [TAP_W-1:0] new_tap, big_tap;
    logic             live_on;

    always_comb begin
        new_tap = tap_of(cfg.code);
        big_tap = (new_tap > st_q.act_tap) ? new_tap : st_q.act_tap;
        live_on = cfg.on & ~kill;
        st_d      = st_q;
        st_d.tick = st_q.act_on & live_on & fall[st_q.act_tap];
        if (!live_on) begin
            st_d.act_on = 1'b0;
        end else if (!st_q.act_on) begin
            if (fall[new_tap]) begin
                st_d.act_on  = 1'b1;
                st_d.act_tap = new_tap;
            end
        end else if (fall[big_tap]) begin
            st_d.act_tap = new_tap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = st_q.tick;

    // R4
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tick |=> !st_q.tick);

    // R9
    off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.act_on |-> !st_q.tick);

endmodule

// File: rtl/presc_top.sv
module presc_top
    import presc_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int WIDE_SHIFT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       presc_on,
    input  logic       cfg_we,
    input  logic       cfg_addr,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       tick_tmr2,
    output logic       tick_tmr3,
    output logic       tick_adc
);
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]      kill;
    logic [CNT_W-1:0]       fall;
    logic [NUM_CH-1:0]      ticks;

    presc_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg),
        .kill  (kill)
    );

    presc_divider #(.CNT_W(CNT_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (presc_on),
        .fall  (fall)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        presc_channel #(
            .CNT_W      (CNT_W),
            .WIDE       (c == CH_TMR2),
            .WIDE_SHIFT (WIDE_SHIFT)
        ) u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .cfg   (cfg[c]),
            .kill  (kill[c]),
            .fall  (fall),
            .tick  (ticks[c])
        );
    end

    assign tick_tmr2 = ticks[CH_TMR2];
    assign tick_tmr3 = ticks[CH_TMR3];
    assign tick_adc  = ticks[CH_ADC];

    // R5
    master_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !presc_on |=> (!tick_tmr2 && !tick_tmr3 && !tick_adc));

    // R9
    adc_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr && !cfg_wdata[3]) |=> !tick_adc);

    // R9
    tmr_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_addr && !cfg_wdata[7]) |=> !tick_tmr3);

endmodule

// File: tb/sim_presc_top.sv
module sim_presc_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       presc_on = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       tick_tmr2, tick_tmr3, tick_adc;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    presc_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_on  (presc_on),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tick_tmr2 (tick_tmr2),
        .tick_tmr3 (tick_tmr3),
        .tick_adc  (tick_adc)
    );

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic tick_of(int ch);
        case (ch)
            0:       return tick_tmr2;
            1:       return tick_tmr3;
            default: return tick_adc;
        endcase
    endfunction

    function automatic int ratio_of(int ch, int code);
        if (code < 6)  return 2 << code;
        if (ch == 0)   return (code == 6) ? 2048 : 4096;
        return (code == 6) ? 128 : 256;
    endfunction

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic count_ticks(int ch, int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_of(ch)) n++;
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int n0, n1, n2;
        rd(1'b0, d); chk("R6 reg0", d, 8'h00);
        rd(1'b1, d); chk("R6 reg1", d, 8'h00);
        n0 = 0; n1 = 0; n2 = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            n0 += tick_tmr2; n1 += tick_tmr3; n2 += tick_adc;
        end
        chk("R6 ticks", n0 + n1 + n2, 0);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(1'b1, 8'hFF); rd(1'b1, d); chk("R7 reserved", d, 8'h0F);
        wr(1'b0, 8'hA5); rd(1'b0, d); chk("R7 reg0", d, 8'hA5);
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    endtask

    task automatic t_sweep();
        int n, ratio;
        for (int ch = 0; ch < 3; ch++) begin
            for (int code = 0; code < 8; code++) begin
                ratio = ratio_of(ch, code);
                if (ch == 2) begin
                    wr(1'b1, 8'h00);
                    wr(1'b1, 8'(8 | code));
                end else begin
                    wr(1'b0, 8'h00);
                    wr(1'b0, (ch == 0) ? 8'(8 | code) : 8'((8 | code) << 4));
                end
                repeat (2 * ratio + 4) @(negedge clk);
                count_ticks(ch, 4 * ratio, n);
                if (code < 6)       chk($sformatf("R1 ch%0d code%0d", ch, code), n, 4);
                else if (ch == 0)   chk($sformatf("R3 code%0d", code), n, 4);
                else                chk($sformatf("R2 ch%0d code%0d", ch, code), n, 4);
            end
        end
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    endtask

    task automatic t_master();
        int n1, n2;
        wr(1'b0, 8'h90);
        wr(1'b1, 8'h08);
        repeat (20) @(negedge clk);
        presc_on = 1'b0;
        @(negedge clk);
        n1 = 0; n2 = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            n1 += tick_tmr3; n2 += tick_adc;
        end
        chk("R5 off tmr3", n1, 0);
        chk("R5 off adc", n2, 0);
        presc_on = 1'b1;
        repeat (10) @(negedge clk);
        n1 = 0; n2 = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            n1 += tick_tmr3; n2 += tick_adc;
        end
        chk("R5 resume tmr3", n1, 10);
        chk("R5 resume adc", n2, 20);
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
    endtask

    task automatic t_kill();
        int n;
        wr(1'b1, 8'h08);
        repeat (12) @(negedge clk);
        count_ticks(2, 8, n);
        chk("R9 running", n, 4);
        cfg_we = 1'b1; cfg_addr = 1'b1; cfg_wdata = 8'h00;
        @(negedge clk);
        cfg_we = 1'b0;
        n = tick_adc;
        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            n += tick_adc;
        end
        chk("R9 after off", n, 0);
    endtask

    task automatic t_change(logic [7:0] first, logic [7:0] second,
                            int gap_new, int min_new, string tag);
        int cyc, last, bad, n_new, g;
        wr(1'b0, 8'h00);
        wr(1'b0, first);
        repeat (600) @(negedge clk);
        cyc = 0; last = -1; bad = 0; n_new = 0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            if (i == 20) begin
                cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = second;
            end else if (i == 21) begin
                cfg_we = 1'b0;
            end
            cyc++;
            if (tick_tmr3) begin
                if (last >= 0) begin
                    g = cyc - last;
                    if (g != 2 && g != 256) bad++;
                    if (g == gap_new) n_new++;
                end
                last = cyc;
            end
        end
        chk({"R8 bad gaps ", tag}, bad, 0);
        chk({"R8 new rate ", tag}, (n_new >= min_new) ? 1 : 0, 1);
    endtask

    task automatic t_parallel();
        int n0, n1, n2;
        wr(1'b0, 8'h00); wr(1'b1, 8'h00);
        wr(1'b0, 8'h9A);
        wr(1'b1, 8'h08);
        repeat (40) @(negedge clk);
        n0 = 0; n1 = 0; n2 = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            n0 += tick_tmr2; n1 += tick_tmr3; n2 += tick_adc;
        end
        chk("R10 tmr2 /8", n0, 8);
        chk("R10 tmr3 /4", n1, 16);
        chk("R10 adc /2", n2, 32);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_sweep();
        t_master();
        t_kill();
        t_change(8'h80, 8'hF0, 256, 4, "up");
        t_change(8'hF0, 8'h80, 2, 100, "down");
        t_parallel();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL all watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule